// File: doc/BRIEF.md
# Overlapping Window Energy Trigger

This block forms a fast first-level accept from one trigger region of a calorimeter. Each clock it receives a flat vector of digitized channel amplitudes, where every channel already carries the sum of a 2x2 patch of towers. The channels form a grid of rows by columns. The block adds each 2x2 neighbourhood of channels into one window sum covering a 4x4 tower area. The windows step by one channel in both directions, so neighbouring windows share channels. Each window sum is compared with its own programmable threshold. The result is a registered per-window hit vector and a registered accept flag that is the OR of all hits.

Thresholds are loaded through a small write port, one window per write, addressed by window index. A new sample vector can be presented on every clock. The result for each vector appears a fixed number of cycles later, well inside the time allowed for the first-level decision. With the default grid of 4 rows by 24 columns there are 96 channels of 12 bits and 69 windows of 14 bits.

Top module: `l0_window_trigger`

## Requirements
- R1: Channel i occupies bits [12*i+11 : 12*i] of `samples_i` and sits at grid row i mod 4 and column i div 4, so the readout index is column*4 + row.
- R2: Window w = c*3 + r (r in 0..2, c in 0..22) sums the four channels at rows r and r+1 and columns c and c+1. There are 69 windows, and window w drives `hit_o[w]`.
- R3: A window hits when its 14-bit sum is greater than or equal to its threshold. A sum one below the threshold gives no hit.
- R4: When `thr_we_i` is high on a clock edge and `thr_idx_i` < 69, the 14-bit `thr_val_i` becomes the threshold of window `thr_idx_i` from the next edge on. The other windows keep their thresholds.
- R5: A threshold write whose index is 69 or higher changes no threshold.
- R6: Synchronous reset, active high, clears `hit_o` and `accept_o` and sets every threshold to all ones (16383). A window whose threshold is all ones never hits, even when all of its inputs are at 4095.
- R7: `accept_o` is high exactly when at least one bit of `hit_o` is high, in the same cycle.
- R8: A sample vector captured on clock edge k is reflected in `hit_o` and `accept_o` right after edge k+2. The comparison uses the thresholds held at that edge.
- R9: A new sample vector is accepted on every clock. Results of consecutive vectors do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| samples_i | input | 1152 | 96 channel amplitudes, 12 bits each, in readout order |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_idx_i | input | 7 | Window index of the threshold write |
| thr_val_i | input | 14 | Threshold value to write |
| hit_o | output | 69 | Registered per-window hit flags |
| accept_o | output | 1 | Registered OR of all window hits |

## Verification
The hardest case to produce from the ports is a threshold write that arrives while sample vectors are still moving through the pipeline. The write lands one edge after it is driven, and it must be seen by exactly those vectors that reach the compare stage after it. The random phase interleaves writes at in-range and out-of-range indices with a new random vector on every cycle. The bench model applies each write one step late and evaluates the expected hits only when the result is due, so any off-by-one in threshold timing shows up as a miscompare. Single-channel impulses over every channel and sums set exactly at and one below a threshold cover the grid mapping and the compare boundary.

// File: rtl/wtrig_pkg.sv
package wtrig_pkg;

   localparam int unsigned DEF_ROWS     = 4;
   localparam int unsigned DEF_COLS     = 24;
   localparam int unsigned DEF_SAMPLE_W = 12;
   localparam int unsigned DEF_IDX_W    = 7;

   // position of a channel in the flat readout vector (column-major)
   function automatic int unsigned chan_index(input int unsigned row,
                                              input int unsigned col,
                                              input int unsigned rows);
      return col * rows + row;
   endfunction

   // position of a window in the hit vector (column-major over window origins)
   function automatic int unsigned win_index(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned win_rows);
      return col * win_rows + row;
   endfunction

endpackage

// File: rtl/wtrig_capture.sv
module wtrig_capture #(
   parameter int unsigned WIDTH = 1152
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] q_r;

   always_ff @(posedge clk) begin
      if (rst) q_r <= '0;
      else     q_r <= d_i;
   end

   assign q_o = q_r;

endmodule

// File: rtl/wtrig_thresholds.sv
module wtrig_thresholds #(
   parameter int unsigned N_WIN = 69,
   parameter int unsigned IDX_W = 7,
   parameter int unsigned THR_W = 14
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   we_i,
   input  logic [IDX_W-1:0]       idx_i,
   input  logic [THR_W-1:0]       val_i,
   output logic [N_WIN*THR_W-1:0] thr_o
);

   localparam int unsigned ADDR_SPAN = 1 << IDX_W;

   if (ADDR_SPAN < N_WIN) begin : g_bad_idx
      $error("index width too small for window count");
   end

   logic [THR_W-1:0] thr_q [N_WIN];
   logic             in_range;

   assign in_range = int'(idx_i) < int'(N_WIN);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int w = 0; w < int'(N_WIN); w++) thr_q[w] <= '1;
      end else if (we_i && in_range) begin
         thr_q[idx_i] <= val_i;
      end
   end

   always_comb begin
      for (int w = 0; w < int'(N_WIN); w++) thr_o[w*THR_W +: THR_W] = thr_q[w];
   end

   // writes beyond the window count leave every threshold untouched
   assert_far_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
      (we_i && !in_range) |=> $stable(thr_o));

   // an accepted write is visible at its window on the following cycle
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
      (we_i && in_range) |=> (thr_q[$past(idx_i)] == $past(val_i)));

endmodule

// File: rtl/wtrig_windows.sv
module wtrig_windows
   import wtrig_pkg::*;
#(
   parameter int unsigned N_ROWS        = 4,
   parameter int unsigned N_COLS        = 24,
   parameter int unsigned SAMPLE_W      = 12,
   parameter bit          CMP_INCLUSIVE = 1'b1
) (
   input  logic                                                 clk,
   input  logic                                                 rst,
   input  logic [N_ROWS*N_COLS*SAMPLE_W-1:0]                    samples_q_i,
   input  logic [(N_ROWS-1)*(N_COLS-1)*(SAMPLE_W+2)-1:0]        thr_i,
   output logic [(N_ROWS-1)*(N_COLS-1)-1:0]                     hit_o,
   output logic                                                 accept_o
);

   localparam int unsigned WR     = N_ROWS - 1;
   localparam int unsigned WC     = N_COLS - 1;
   localparam int unsigned N_WIN  = WR * WC;
   localparam int unsigned PAIR_W = SAMPLE_W + 1;
   localparam int unsigned SUM_W  = SAMPLE_W + 2;

   // stage 2: vertical pairs, shared by the two windows left and right of a column
   logic [PAIR_W-1:0] pair_d [WR][N_COLS];
   logic [PAIR_W-1:0] pair_q [WR][N_COLS];

   always_comb begin
      for (int unsigned r = 0; r < WR; r++) begin
         for (int unsigned c = 0; c < N_COLS; c++) begin
            pair_d[r][c] =
               PAIR_W'(samples_q_i[chan_index(r,     c, N_ROWS)*SAMPLE_W +: SAMPLE_W]) +
               PAIR_W'(samples_q_i[chan_index(r + 1, c, N_ROWS)*SAMPLE_W +: SAMPLE_W]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int unsigned r = 0; r < WR; r++)
            for (int unsigned c = 0; c < N_COLS; c++) pair_q[r][c] <= '0;
      end else begin
         pair_q <= pair_d;
      end
   end

   // stage 3: horizontal add of neighbouring pairs, then compare
   logic [SUM_W-1:0] wsum  [N_WIN];
   logic [SUM_W-1:0] thr_w [N_WIN];
   logic [N_WIN-1:0] dis_mask;
   logic [N_WIN-1:0] hit_d;
   logic [N_WIN-1:0] hit_q;
   logic             accept_q;

   always_comb begin
      for (int unsigned r = 0; r < WR; r++) begin
         for (int unsigned c = 0; c < WC; c++) begin
            wsum[win_index(r, c, WR)] = SUM_W'(pair_q[r][c]) + SUM_W'(pair_q[r][c+1]);
         end
      end
   end

   always_comb begin
      for (int unsigned w = 0; w < N_WIN; w++) begin
         thr_w[w]    = thr_i[w*SUM_W +: SUM_W];
         dis_mask[w] = &thr_i[w*SUM_W +: SUM_W];
      end
   end

   if (CMP_INCLUSIVE) begin : g_cmp_ge
      always_comb begin
         for (int unsigned w = 0; w < N_WIN; w++) hit_d[w] = (wsum[w] >= thr_w[w]);
      end
   end else begin : g_cmp_gt
      always_comb begin
         for (int unsigned w = 0; w < N_WIN; w++) hit_d[w] = (wsum[w] > thr_w[w]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hit_q    <= '0;
         accept_q <= 1'b0;
      end else begin
         hit_q    <= hit_d;
         accept_q <= |hit_d;
      end
   end

   assign hit_o    = hit_q;
   assign accept_o = accept_q;

   // the accept flag and the hit vector agree every cycle
   assert_accept_is_or_R7: assert property (@(posedge clk) disable iff (rst)
      accept_q == (|hit_q));

   // a window holding an all-ones threshold never reports a hit
   assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (rst)
      (hit_q & $past(dis_mask)) == '0);

   for (genvar w = 0; w < int'(N_WIN); w++) begin : g_hit_chk
      // a hit needs a sum that reached the threshold one cycle before
      assert_hit_needs_sum_R3: assert property (@(posedge clk) disable iff (rst)
         hit_q[w] |-> ($past(wsum[w]) >= $past(thr_w[w])));
   end

endmodule

// File: rtl/l0_window_trigger.sv
module l0_window_trigger
   import wtrig_pkg::*;
#(
   parameter int unsigned N_ROWS        = DEF_ROWS,
   parameter int unsigned N_COLS        = DEF_COLS,
   parameter int unsigned SAMPLE_W      = DEF_SAMPLE_W,
   parameter int unsigned IDX_W         = DEF_IDX_W,
   parameter bit          CMP_INCLUSIVE = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic [N_ROWS*N_COLS*SAMPLE_W-1:0]       samples_i,
   input  logic                                    thr_we_i,
   input  logic [IDX_W-1:0]                        thr_idx_i,
   input  logic [SAMPLE_W+1:0]                     thr_val_i,
   output logic [(N_ROWS-1)*(N_COLS-1)-1:0]        hit_o,
   output logic                                    accept_o
);

   localparam int unsigned N_CH  = N_ROWS * N_COLS;
   localparam int unsigned N_WIN = (N_ROWS - 1) * (N_COLS - 1);
   localparam int unsigned SUM_W = SAMPLE_W + 2;
   localparam int unsigned BUS_W = N_CH * SAMPLE_W;

   if (N_ROWS < 2 || N_COLS < 2) begin : g_bad_grid
      $error("grid needs at least 2 rows and 2 columns");
   end
   if (SAMPLE_W < 1) begin : g_bad_width
      $error("sample width must be positive");
   end

   logic [BUS_W-1:0]       samples_q;
   logic [N_WIN*SUM_W-1:0] thr_flat;

   // stage 1: register the incoming vector
   wtrig_capture #(
      .WIDTH (BUS_W)
   ) u_capture (
      .clk (clk),
      .rst (rst),
      .d_i (samples_i),
      .q_o (samples_q)
   );

   wtrig_thresholds #(
      .N_WIN (N_WIN),
      .IDX_W (IDX_W),
      .THR_W (SUM_W)
   ) u_thresholds (
      .clk   (clk),
      .rst   (rst),
      .we_i  (thr_we_i),
      .idx_i (thr_idx_i),
      .val_i (thr_val_i),
      .thr_o (thr_flat)
   );

   wtrig_windows #(
      .N_ROWS        (N_ROWS),
      .N_COLS        (N_COLS),
      .SAMPLE_W      (SAMPLE_W),
      .CMP_INCLUSIVE (CMP_INCLUSIVE)
   ) u_windows (
      .clk         (clk),
      .rst         (rst),
      .samples_q_i (samples_q),
      .thr_i       (thr_flat),
      .hit_o       (hit_o),
      .accept_o    (accept_o)
   );

endmodule

// File: tb/l0_window_trigger_tb.sv
module l0_window_trigger_tb;

   localparam int NCH  = 96;
   localparam int NW   = 69;
   localparam int SW   = 12;
   localparam int TW   = 14;
   localparam int BUSW = NCH * SW;

   logic            clk = 1'b0;
   logic            rst;
   logic [BUSW-1:0] samples;
   logic            we;
   logic [6:0]      idx;
   logic [TW-1:0]   val;
   logic [NW-1:0]   hit_o;
   logic            accept_o;

   l0_window_trigger u_dut (
      .clk       (clk),
      .rst       (rst),
      .samples_i (samples),
      .thr_we_i  (we),
      .thr_idx_i (idx),
      .thr_val_i (val),
      .hit_o     (hit_o),
      .accept_o  (accept_o)
   );

   always #2 clk = ~clk;

   int              vectors = 0;
   int              errors  = 0;
   string           cur_req = "R6";
   logic [TW-1:0]   thr_m [NW];
   logic [BUSW-1:0] pipe_s [3];
   bit              pipe_v [3];
   bit              pend_we;
   int              pend_idx;
   int              pend_val;

   function automatic logic [NW-1:0] exp_hits(input logic [BUSW-1:0] s);
      logic [NW-1:0] h;
      for (int c = 0; c < 23; c++) begin
         for (int r = 0; r < 3; r++) begin
            int sum;
            sum = int'(s[(c*4+r)*SW +: SW]) + int'(s[(c*4+r+1)*SW +: SW]) +
                  int'(s[((c+1)*4+r)*SW +: SW]) + int'(s[((c+1)*4+r+1)*SW +: SW]);
            h[c*3+r] = (sum >= int'(thr_m[c*3+r]));
         end
      end
      return h;
   endfunction

   function automatic logic [BUSW-1:0] one_chan(input int ch, input int v);
      logic [BUSW-1:0] s;
      s = '0;
      s[ch*SW +: SW] = SW'(v);
      return s;
   endfunction

   function automatic logic [BUSW-1:0] rand_bus();
      logic [BUSW-1:0] s;
      for (int i = 0; i < NCH; i++) s[i*SW +: SW] = SW'($urandom_range(0, 4095));
      return s;
   endfunction

   task automatic check_vec(input logic [NW-1:0] exp);
      vectors++;
      if (hit_o !== exp) begin
         errors++;
         $display("FAIL %s hit_o actual %h expected %h", cur_req, hit_o, exp);
      end
      if (accept_o !== (|exp)) begin
         errors++;
         $display("FAIL R7 accept_o actual %b expected %b", accept_o, |exp);
      end
   endtask

   // one clock: check the result due now, then drive the next inputs
   task automatic step(input logic [BUSW-1:0] s, input bit w_en, input int w_idx,
                       input int w_val);
      @(negedge clk);
      if (pipe_v[2]) check_vec(exp_hits(pipe_s[2]));
      if (pend_we && pend_idx < NW) thr_m[pend_idx] = TW'(pend_val);
      pend_we  = w_en;
      pend_idx = w_idx;
      pend_val = w_val;
      pipe_s[2] = pipe_s[1]; pipe_v[2] = pipe_v[1];
      pipe_s[1] = pipe_s[0]; pipe_v[1] = pipe_v[0];
      pipe_s[0] = s;         pipe_v[0] = 1'b1;
      samples = s;
      we      = w_en;
      idx     = 7'(w_idx);
      val     = TW'(w_val);
   endtask

   task automatic set_thr(input int w, input int v);
      step('0, 1'b1, w, v);
   endtask

   task automatic flush();
      repeat (3) step('0, 1'b0, 0, 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual cycles 50000 expected fewer");
      summary();
      $finish;
   end

   initial begin
      logic [BUSW-1:0] s;
      void'($urandom(32'd20240611));
      rst = 1'b1; samples = '0; we = 1'b0; idx = '0; val = '0;
      pend_we = 1'b0; pend_idx = 0; pend_val = 0;
      for (int w = 0; w < NW; w++) thr_m[w] = '1;
      for (int i = 0; i < 3; i++) pipe_v[i] = 1'b0;

      // R6: reset state
      repeat (3) @(negedge clk);
      cur_req = "R6";
      check_vec('0);
      rst = 1'b0;

      // R6: full-scale inputs against all-ones thresholds give no hit
      s = '1;
      repeat (5) step(s, 1'b0, 0, 0);
      flush();

      // R1 R2: single-channel impulses over the whole grid with threshold 1
      cur_req = "R4";
      for (int w = 0; w < NW; w++) set_thr(w, 1);
      cur_req = "R1 R2";
      for (int ch = 0; ch < NCH; ch++) step(one_chan(ch, 1), 1'b0, 0, 0);
      flush();

      // R3: compare boundary on window 16 (row 1, column 5: channels 21 22 25 26)
      cur_req = "R4";
      for (int w = 0; w < NW; w++) set_thr(w, (w == 16) ? 100 : 16383);
      cur_req = "R3";
      s = '0;
      s[21*SW +: SW] = 25; s[22*SW +: SW] = 25; s[25*SW +: SW] = 25; s[26*SW +: SW] = 25;
      step(s, 1'b0, 0, 0);
      s[21*SW +: SW] = 24;
      step(s, 1'b0, 0, 0);
      step(one_chan(0, 4095), 1'b0, 0, 0);
      set_thr(16, 16380);
      flush();
      s = '1;
      step(s, 1'b0, 0, 0);
      set_thr(16, 16381);
      flush();
      step(s, 1'b0, 0, 0);
      flush();

      // R5: writes beyond the window count are dropped
      cur_req = "R5";
      set_thr(16, 16383);
      set_thr(69, 0);
      set_thr(70, 0);
      set_thr(100, 0);
      set_thr(127, 0);
      repeat (4) step('0, 1'b0, 0, 0);
      flush();

      // R4: single in-range writes change only their own window
      cur_req = "R4";
      set_thr(68, 0);
      set_thr(0, 0);
      repeat (4) step('0, 1'b0, 0, 0);
      flush();

      // R8 R9: random vectors every cycle with interleaved threshold writes
      cur_req = "R8 R9";
      for (int w = 0; w < NW; w++) set_thr(w, int'($urandom_range(5000, 11000)));
      for (int n = 0; n < 400; n++) begin
         if (n % 7 == 3)
            step(rand_bus(), 1'b1, int'($urandom_range(0, 127)), int'($urandom_range(4000, 12000)));
         else
            step(rand_bus(), 1'b0, 0, 0);
      end
      flush();

      summary();
      $finish;
   end

endmodule